// File: doc/BRIEF.md
# Externally Triggered Single-Channel ADC Sequencer

This block is the digital control around an analog-to-digital converter core. It watches an asynchronous trigger pin and, on each valid edge, starts one conversion of a channel chosen in a mode register. The converter core is reached through a start/done handshake: the sequencer issues a one-cycle start pulse with the channel index, and the core later returns a done pulse with a 10-bit sample.

Each channel owns a result register, and a sample is stored only in the register of the channel that produced it. When the sample is stored, a busy flag drops and a one-cycle end-of-conversion interrupt pulse is raised. Nothing repeats automatically: every conversion needs a fresh valid trigger edge. Software sets the enable bit, the edge choice and the channel through a simple write/read register bus, then reads the per-channel results. The channel count `NCH` is a parameter; 6 and 8 are the intended settings.

Top module: `trig_adc_seq`

## Requirements
- R1: After reset the mode register reads 0 (enable off, edge code 00, channel 0), the status register reads 0, every result register reads 0 and `eoc_irq` is low.
- R2: The edge code in mode bits [2:1] selects the valid trigger edge: 01 rising only, 10 falling only, 11 both edges, 00 no edge at all. An edge that the code does not select starts no conversion.
- R3: The trigger passes a two-flop synchronizer; after `trig_in` changes just before a rising clock edge, `conv_start` is low after the second rising edge and high after the third.
- R4: `conv_start` is a single-cycle pulse, and `conv_chan` carries the channel from mode bits [10:8] for the whole conversion.
- R5: The sample on `conv_data` in the `conv_done` cycle is written only to the result register of the converting channel; all other result registers keep their values.
- R6: One cycle after `conv_done`, `eoc_irq` is high for exactly one cycle and the busy bit (status bit 0) reads 0.
- R7: While the enable bit (mode bit 0) is 0, no trigger edge starts a conversion.
- R8: A valid edge that arrives while a conversion is in progress is dropped, neither starting nor queueing a conversion.
- R9: One valid edge yields exactly one conversion; no further conversion occurs without another valid edge.
- R10: Register map: address 0 mode (read/write), address 1 status (read only, busy in bit 0), address 8+k result of channel k zero-extended; read data appears on `bus_rdata` one cycle after `bus_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data |
| trig_in | input | 1 | Asynchronous external trigger |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_chan | output | 3 | Channel index for the conversion |
| conv_done | input | 1 | Core done pulse |
| conv_data | input | 10 | Core sample, valid with `conv_done` |
| eoc_irq | output | 1 | One-cycle end-of-conversion interrupt |

## Verification
The properties rely on the converter core answering each start pulse with exactly one done pulse, no earlier than the cycle after the start and never while the sequencer is idle. The bench's behavioural core keeps to this by counting a fixed latency from each observed start and raising done once at its end. Trigger changes are held for many cycles, so every level reaches the synchronizer cleanly and each intended edge is seen exactly once.

// File: rtl/trig_adc_pkg.sv
package trig_adc_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned MODE_ADDR = 0;
  localparam int unsigned STAT_ADDR = 1;
  localparam int unsigned RES_BASE  = 8;
  localparam int unsigned CHAN_LSB  = 8;
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    trig_in,
  input  trig_adc_pkg::edge_sel_e edge_sel,
  output logic                    hit
);
  import trig_adc_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= trig_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= 1'b0;
          else     sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

  always_comb begin
    unique case (edge_sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_adc_results.sv
module trig_adc_results #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 10,
  parameter int unsigned CW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] res_q [NCH];

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_res
      always_ff @(posedge clk) begin
        if (rst)                                 res_q[k] <= '0;
        else if (wr_en && wr_idx == CW'(k))      res_q[k] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NCH; k++) begin
      if (rd_idx == CW'(k)) rd_data = res_q[k];
    end
  end
endmodule

// File: rtl/trig_adc_seq.sv
module trig_adc_seq #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 10,
  parameter int unsigned AW  = 5,
  parameter int unsigned BW  = 16,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          trig_in,
  output logic          conv_start,
  output logic [CW-1:0] conv_chan,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  output logic          eoc_irq
);
  import trig_adc_pkg::*;

  logic          en_q;
  edge_sel_e     edge_q;
  logic [CW-1:0] chan_q;
  logic          busy_q;
  logic [CW-1:0] act_chan_q;
  logic          start_q;
  logic          irq_q;
  logic [BW-1:0] rdata_q;
  logic          hit;
  logic          res_wr;
  logic [AW-1:0] res_off;
  logic          res_sel;
  logic [DW-1:0] res_rd;
  logic          unused_wdata;

  assign unused_wdata = ^bus_wdata;

  trig_edge_det #(.SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst(rst), .trig_in(trig_in), .edge_sel(edge_q), .hit(hit)
  );

  assign res_wr  = busy_q & conv_done;
  assign res_off = bus_addr - AW'(RES_BASE);
  assign res_sel = (bus_addr >= AW'(RES_BASE)) && (res_off < AW'(NCH));

  trig_adc_results #(.NCH(NCH), .DW(DW), .CW(CW)) u_res (
    .clk(clk), .rst(rst),
    .wr_en(res_wr), .wr_idx(act_chan_q), .wr_data(conv_data),
    .rd_idx(res_off[CW-1:0]), .rd_data(res_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      edge_q <= EDGE_NONE;
      chan_q <= '0;
    end else if (bus_we && bus_addr == AW'(MODE_ADDR)) begin
      en_q   <= bus_wdata[0];
      edge_q <= edge_sel_e'(bus_wdata[2:1]);
      chan_q <= bus_wdata[CHAN_LSB +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      act_chan_q <= '0;
      start_q    <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      if (busy_q) begin
        if (conv_done) begin
          busy_q <= 1'b0;
          irq_q  <= 1'b1;
        end
      end else if (en_q && hit) begin
        busy_q     <= 1'b1;
        start_q    <= 1'b1;
        act_chan_q <= chan_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (bus_addr == AW'(MODE_ADDR)) begin
        rdata_q[0]              <= en_q;
        rdata_q[2:1]            <= edge_q;
        rdata_q[CHAN_LSB +: CW] <= chan_q;
      end else if (bus_addr == AW'(STAT_ADDR)) begin
        rdata_q[0] <= busy_q;
      end else if (res_sel) begin
        rdata_q[DW-1:0] <= res_rd;
      end
    end
  end

  assign bus_rdata  = rdata_q;
  assign conv_start = start_q;
  assign conv_chan  = act_chan_q;
  assign eoc_irq    = irq_q;
endmodule

// File: rtl/trig_adc_seq_chk.sv
module trig_adc_seq_chk #(
  parameter int unsigned CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          conv_start,
  input logic [CW-1:0] conv_chan,
  input logic          conv_done,
  input logic          eoc_irq,
  input logic          busy,
  input logic          en
);
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  p_chan_held_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !conv_start) |-> $stable(conv_chan));

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    eoc_irq |=> !eoc_irq);

  p_done_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && conv_done) |=> (!busy && eoc_irq));

  p_enable_gate_r7: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(en));

  p_no_retrigger_r8: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !$past(busy));

  p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);
endmodule

bind trig_adc_seq trig_adc_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .conv_start(conv_start), .conv_chan(conv_chan),
  .conv_done(conv_done), .eoc_irq(eoc_irq), .busy(busy_q), .en(en_q)
);

// File: tb/trig_adc_seq_bench.sv
`timescale 1ns/1ps
module trig_adc_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        trig_in = 1'b0;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic        eoc_irq;

  int errors = 0;
  int checks = 0;
  int n_start = 0;
  int n_irq = 0;
  int core_lat = 12;
  int lat_cnt = 0;
  logic [2:0] mchan = '0;
  logic [9:0] exp_res [8];

  always #4 clk = ~clk;

  trig_adc_seq u_trig_adc_seq (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .eoc_irq(eoc_irq)
  );

  // behavioural converter core: fixed latency, one done per start
  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (!rst) begin
      if (conv_start) begin
        lat_cnt = core_lat;
        mchan   = conv_chan;
        n_start++;
      end else if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          conv_done <= 1'b1;
          conv_data <= {mchan, 7'(n_start)};
          exp_res[mchan] = {mchan, 7'(n_start)};
        end
      end
      if (eoc_irq) n_irq++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic reg_read(input int a, output int v);
    @(negedge clk);
    bus_addr = 5'(a);
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  function automatic int mode_word(input int en, input int edge_code, input int ch);
    return (ch << 8) | (edge_code << 1) | en;
  endfunction

  task automatic set_trig_wait(input logic v);
    @(negedge clk);
    trig_in = v;
    repeat (40) @(negedge clk);
  endtask

  task automatic check_results(input string tag);
    int v;
    for (int k = 0; k < 8; k++) begin
      reg_read(8 + k, v);
      chk(tag, v, int'(exp_res[k]));
    end
  endtask

  task automatic t_reset_r1();
    int v;
    reg_read(0, v); chk("R1 mode", v, 0);
    reg_read(1, v); chk("R1 status", v, 0);
    chk("R1 irq", int'(eoc_irq), 0);
    check_results("R1 results");
  endtask

  task automatic t_timing_r3();
    int v, s0, i0;
    reg_write(0, mode_word(1, 1, 2));
    reg_read(0, v); chk("R10 mode readback", v, mode_word(1, 1, 2));
    s0 = n_start; i0 = n_irq;
    @(negedge clk); trig_in = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R3 start not yet", int'(conv_start), 0);
    @(posedge clk); #1;
    chk("R3 start", int'(conv_start), 1);
    chk("R4 channel", int'(conv_chan), 2);
    @(posedge clk); #1;
    chk("R4 single pulse", int'(conv_start), 0);
    reg_read(1, v); chk("R10 busy", v, 1);
    repeat (40) @(negedge clk);
    chk("R9 one conversion", n_start - s0, 1);
    chk("R6 one irq cycle", n_irq - i0, 1);
    reg_read(1, v); chk("R6 status cleared", v, 0);
    check_results("R5 rising ch2");
  endtask

  task automatic t_done_irq_r6();
    int s0;
    reg_write(0, mode_word(1, 2, 4));
    s0 = n_start;
    @(negedge clk); trig_in = 1'b0;
    wait (conv_done == 1'b1);
    @(posedge clk); #1;
    chk("R6 irq after done", int'(eoc_irq), 1);
    @(posedge clk); #1;
    chk("R6 irq drops", int'(eoc_irq), 0);
    repeat (20) @(negedge clk);
    chk("R2 falling converts", n_start - s0, 1);
    check_results("R5 falling ch4");
  endtask

  task automatic t_edges_r2();
    int s0;
    // falling-only: a rise must not convert
    s0 = n_start; set_trig_wait(1'b1);
    chk("R2 rise ignored on falling code", n_start - s0, 0);
    // rising-only: a fall must not convert
    reg_write(0, mode_word(1, 1, 5));
    s0 = n_start; set_trig_wait(1'b0);
    chk("R2 fall ignored on rising code", n_start - s0, 0);
    // both edges on channel 7
    reg_write(0, mode_word(1, 3, 7));
    s0 = n_start; set_trig_wait(1'b1);
    chk("R2 both rise", n_start - s0, 1);
    check_results("R5 both rise ch7");
    reg_write(0, mode_word(1, 3, 0));
    s0 = n_start; set_trig_wait(1'b0);
    chk("R2 both fall", n_start - s0, 1);
    check_results("R5 both fall ch0");
    // code 00 selects nothing
    reg_write(0, mode_word(1, 0, 1));
    s0 = n_start; set_trig_wait(1'b1); set_trig_wait(1'b0);
    chk("R2 code00 no edge", n_start - s0, 0);
  endtask

  task automatic t_enable_r7();
    int s0, v;
    reg_write(0, mode_word(0, 3, 3));
    s0 = n_start; set_trig_wait(1'b1); set_trig_wait(1'b0);
    chk("R7 disabled no conversion", n_start - s0, 0);
    reg_read(1, v); chk("R7 status idle", v, 0);
    check_results("R7 results untouched");
  endtask

  task automatic t_busy_r8();
    int s0, i0;
    core_lat = 30;
    reg_write(0, mode_word(1, 3, 6));
    s0 = n_start; i0 = n_irq;
    @(negedge clk); trig_in = 1'b1;
    repeat (12) @(negedge clk);
    trig_in = 1'b0;
    repeat (80) @(negedge clk);
    chk("R8 edge during busy dropped", n_start - s0, 1);
    chk("R8 one irq", n_irq - i0, 1);
    check_results("R8 results ch6");
    core_lat = 12;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) exp_res[k] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_r1();
    t_timing_r3();
    t_done_irq_r6();
    t_edges_r2();
    t_enable_r7();
    t_busy_r8();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule